// File: doc/BRIEF.md
# Wrapping Command-Completion Event Counter

This block keeps per-channel completion bookkeeping for a transfer engine. Each time the engine finishes a command it pulses an event input, and a hardware-owned done count advances by one. Software keeps its own processed count inside the same 32-bit register. It acknowledges work by writing back the done value it last read. A level interrupt stays high while the two counts differ.

Both counts are six bits wide and wrap modulo 64, so the number of events still to be handled is the difference of the two counts modulo 64. Software can never overwrite the done count. An event that lands between software's read and its acknowledge write is therefore kept, and it holds the interrupt up. The first event after a command list starts is counted like any other event.

Top module: `cmd_evt_counter`

## Requirements
- R1: The read word places the done count in bits 5:0, the interrupt-active flag in bit 8 and the processed count in bits 21:16; every other bit reads as zero.
- R2: Each cycle with the event input high raises the done count by exactly one, modulo 64, so 63 wraps to 0; the first event is counted like any other.
- R3: A register write never changes the done count or the interrupt-active flag, whatever the written bits 5:0 and bit 8 hold.
- R4: A register write loads the processed count from written bits 21:16 at the next clock edge.
- R5: When the counts differ after a clock edge, the interrupt-active flag and the interrupt output are high after the following edge.
- R6: When the counts are equal after a clock edge, the interrupt-active flag and the interrupt output are low after the following edge.
- R7: An event and a write in the same cycle both take effect; if the written value equals the done count before the increment, the interrupt stays asserted.
- R8: Pending events are counted modulo 64, so the interrupt stays high after the done count wraps to a value below the processed count.
- R9: Synchronous active-low reset clears both counts and the interrupt-active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 1 | One command event per cycle held high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest situation to reach is an acknowledge that races a new event. Software writes back the old done value in the same cycle that the done count advances, and the interrupt must stay asserted. The stimulus table places an event and a write in one cycle, with the written value equal to the pre-increment count. A directed run of single events carries the done count past 63 and round to 0 while the processed count is still 4. This checks that pending work is measured modulo 64 and not by a plain comparison of magnitudes.

// File: rtl/cmd_evt_pkg.sv
// Package: shared field geometry of the completion register.
// Assumes a 32-bit register with two equal-width counters.
package cmd_evt_pkg;
    localparam int REG_W    = 32;
    localparam int CNT_W    = 6;
    localparam int DONE_LSB = 0;
    localparam int ACT_BIT  = 8;
    localparam int PROC_LSB = 16;
endpackage

// File: rtl/evt_done_ctr.sv
// evt_done_ctr: hardware-owned done count that advances once per event.
// Assumes at most one event per cycle; the count wraps at 2**CNT_W.
module evt_done_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    output logic [CNT_W-1:0] done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count events with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   done <= '0;
        else if (evt) done <= done + ONE;
    end
endmodule

// File: rtl/proc_cnt_reg.sv
// proc_cnt_reg: software-owned processed count, loaded by register writes.
// Assumes the write data field is already extracted.
module proc_cnt_reg #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] proc_cnt
);
    // Hold the last acknowledged count.
    always_ff @(posedge clk) begin
        if (!rst_n)    proc_cnt <= '0;
        else if (load) proc_cnt <= load_val;
    end
endmodule

// File: rtl/irq_level_flag.sv
// irq_level_flag: registered pending flag, high while the counts differ.
// Assumes both counts are registers; the flag lags them by one edge.
module irq_level_flag #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] done,
    input  logic [CNT_W-1:0] proc_cnt,
    output logic             active
);
    logic [CNT_W-1:0] pending;

    // Pending work modulo 2**CNT_W.
    always_comb pending = done - proc_cnt;

    // Register the pending-nonzero condition.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= (pending != '0);
    end
endmodule

// File: rtl/cmd_evt_counter.sv
// cmd_evt_counter: completion register with done/processed counts and a
// level interrupt. Software writes only the processed field; the done
// count and the active flag belong to hardware. Assumes single-cycle
// event pulses and a synchronous active-low reset.
module cmd_evt_counter
    import cmd_evt_pkg::*;
#(
    parameter int CNT_W = cmd_evt_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pulse,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] done_q;
    logic [CNT_W-1:0] proc_q;
    logic             act_q;

    evt_done_ctr #(.CNT_W(CNT_W)) u_done (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .done(done_q)
    );

    proc_cnt_reg #(.CNT_W(CNT_W)) u_proc (
        .clk(clk), .rst_n(rst_n), .load(reg_wr),
        .load_val(reg_wdata[PROC_LSB +: CNT_W]), .proc_cnt(proc_q)
    );

    irq_level_flag #(.CNT_W(CNT_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .done(done_q), .proc_cnt(proc_q),
        .active(act_q)
    );

    // Assemble the read word; unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[DONE_LSB +: CNT_W] = done_q;
        reg_rdata[PROC_LSB +: CNT_W] = proc_q;
        reg_rdata[ACT_BIT]           = act_q;
    end

    // Drive the level interrupt from the flag.
    always_comb irq = act_q;

    // R2: an event advances done by one with wrap
    a_r2_done_step: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> done_q == CNT_W'($past(done_q) + CNT_W'(1)));

    // R3: without an event, done is unchanged even across a write
    a_r3_done_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_pulse |=> $stable(done_q));

    // R4: a write loads the processed field
    a_r4_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> proc_q == $past(reg_wdata[PROC_LSB +: CNT_W]));

    // R5: differing counts raise the interrupt one edge later
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != proc_q) |=> irq);

    // R6: equal counts drop the interrupt one edge later
    a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q == proc_q) |=> !irq);
endmodule

// File: tb/cmd_evt_counter_tb_top.sv
module cmd_evt_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pulse = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    cmd_evt_counter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {evt, wr, wdata[31:0], exp_done[5:0], exp_proc[5:0], exp_act}
    localparam logic [46:0] VEC [NV] = '{
        {1'b1, 1'b0, 32'h0000_0000, 6'd1, 6'd0, 1'b0}, // R2 first event counted
        {1'b0, 1'b0, 32'h0000_0000, 6'd1, 6'd0, 1'b1}, // R5
        {1'b1, 1'b0, 32'h0000_0000, 6'd2, 6'd0, 1'b1}, // R2
        {1'b0, 1'b1, 32'h0002_0000, 6'd2, 6'd2, 1'b1}, // R4
        {1'b0, 1'b0, 32'h0000_0000, 6'd2, 6'd2, 1'b0}, // R6
        {1'b1, 1'b1, 32'h0002_0000, 6'd3, 6'd2, 1'b0}, // R7
        {1'b0, 1'b0, 32'h0000_0000, 6'd3, 6'd2, 1'b1}, // R7 stays up
        {1'b0, 1'b1, 32'h0003_013F, 6'd3, 6'd3, 1'b1}, // R3 done/act bits ignored
        {1'b0, 1'b0, 32'h0000_0000, 6'd3, 6'd3, 1'b0}, // R6
        {1'b0, 1'b0, 32'h0000_0000, 6'd3, 6'd3, 1'b0}, // R6 stays low
        {1'b1, 1'b1, 32'h0003_0000, 6'd4, 6'd3, 1'b0}, // R7 race ack
        {1'b0, 1'b0, 32'h0000_0000, 6'd4, 6'd3, 1'b1}, // R7 newer event kept
        {1'b0, 1'b1, 32'h0004_0000, 6'd4, 6'd4, 1'b1}, // R4
        {1'b0, 1'b0, 32'h0000_0000, 6'd4, 6'd4, 1'b0}  // R6
    };

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [5:0] d,
                                         input logic [5:0] p, input logic a);
        return {10'd0, p, 7'd0, a, 2'd0, d};
    endfunction

    task automatic step(input logic e, input logic w, input logic [31:0] wd);
        evt_pulse = e; reg_wr = w; reg_wdata = wd;
        @(negedge clk);
        evt_pulse = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset word", reg_rdata, 32'h0);
        check("R9 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VEC[i];
            step(v[46], v[45], v[44:13]);
            // R1: full word layout, reserved bits zero
            check($sformatf("R1 vec %0d word", i), reg_rdata,
                  word(v[12:7], v[6:1], v[0]));
            check($sformatf("R5/R6 vec %0d irq", i), {31'd0, irq},
                  {31'd0, v[0]});
        end

        // R2/R8: run done from 4 up to 63, then wrap to 0 past proc=4
        for (int k = 0; k < 59; k++) step(1'b1, 1'b0, 32'h0);
        check("R2 done reaches 63", reg_rdata, word(6'd63, 6'd4, 1'b1));
        step(1'b1, 1'b0, 32'h0);
        check("R2 done wraps to 0", reg_rdata, word(6'd0, 6'd4, 1'b1));
        step(1'b0, 1'b0, 32'h0);
        check("R8 irq after wrap", {31'd0, irq}, 32'd1);
        step(1'b0, 1'b1, 32'h0000_0000);
        check("R4 ack of wrapped count", reg_rdata, word(6'd0, 6'd0, 1'b1));
        step(1'b0, 1'b0, 32'h0);
        check("R6 irq drops after wrapped ack", {31'd0, irq}, 32'd0);

        // R3: write with only done/act bits set leaves them alone
        step(1'b0, 1'b1, 32'h0000_013F);
        step(1'b0, 1'b0, 32'h0);
        check("R3 write ignored fields", reg_rdata, word(6'd0, 6'd0, 1'b0));

        // R9: reset while pending
        step(1'b1, 1'b1, 32'h0005_0000);
        step(1'b0, 1'b0, 32'h0);
        check("R9 pre-reset pending", reg_rdata, word(6'd1, 6'd5, 1'b1));
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears word", reg_rdata, 32'h0);
        check("R9 reset clears irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done_flag = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule